// File: doc/BRIEF.md
# Five-Channel Reloadable Down-Counter Timer

This block holds five independent down-counters that share one control word and are reached through a simple 32-bit register port with a 0x50-byte window. Each channel has a count buffer that software fills in advance. A manual-update request copies that buffer into the live counter. A start request lets the counter step down by one on every pulse of that channel's tick input, which comes from a prescaler outside the block.

When a running counter at zero receives a tick, the channel has expired. It then sends a one-cycle strobe towards the interrupt logic. With auto-reload set, it refills from its count buffer and keeps counting. Without auto-reload, it halts and clears its own start bit in the control word. The first four channels also keep a compare buffer, which is only stored and read back. Every channel's live count can be read at any time. Writes take effect at the clock edge that samples them. Read data is registered, so it appears one cycle after the address is presented.

Top module: `tmr_bank`

## Requirements
- R1: After reset the control word, all count buffers and all compare buffers read 0, every live count reads 0, all counters are stopped and no expiry strobe is raised.
- R2: For channel x below 4, the count buffer is at byte offset 0x0C+0xC·x and the compare buffer sits 4 bytes above it; both read back what was written. Channel 4 has its count buffer at 0x3C and no compare buffer.
- R3: The control word is at 0x08. For channel x its field starts at bit 0 when x=0 and at bit 4x+4 otherwise, with start at +0, manual update at +1, output invert at +2 and auto-reload at +3. Channel 4 has start at bit 20, manual update at bit 21 and auto-reload at bit 22, and no invert bit. Bits outside these positions read back as 0.
- R4: A control write that takes a channel's manual-update bit from 0 to 1 copies that channel's count buffer into its live counter. A write that leaves the bit at 1 does not copy it again.
- R5: A control write that takes a start bit from 0 to 1 starts that counter. A write that takes it from 1 to 0 stops it, and the counter keeps its value. Both edges are judged against the stored control value.
- R6: A running counter above zero decreases by exactly 1 on each cycle its tick input is high. A counter with no tick, or one that is stopped, keeps its value.
- R7: A running counter at 0 that receives a tick raises that channel's expiry output for exactly the following cycle.
- R8: On expiry with auto-reload set (bit 22 for channel 4), the counter reloads from its count buffer and keeps running. The start bit stays set.
- R9: On expiry with auto-reload clear, the counter halts and the block clears that channel's start bit in the control word. Further ticks change neither the count nor the expiry output.
- R10: The observation word of channel x is at 0x0C+0xC·x+8 for x below 4 and at 0x40 for channel 4. It returns the live counter value, and writes to it have no effect.
- R11: Reads of unmapped or misaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's bus_addr |
| tick_i | input | 5 | Per-channel count enable pulses from the prescaler |
| expire_o | output | 5 | Per-channel one-cycle expiry strobes |

## Verification
The assertions check the following on every cycle, whatever the stimulus:
- a load from the count buffer after a manual-update edge;
- the one-step decrement and the hold of a counter without a tick;
- the strobe timing after a zero-count tick;
- the reload on auto-reload expiry, and the halt and start-bit clearing on one-shot expiry.

Only the bench's scenarios can show how these behaviours look through the register port:
- the address map and the masking of unused control bits;
- that a held manual-update bit does not reload;
- that a stopped counter resumes from its held value;
- that channel 4 takes its auto-reload from bit 22;
- that unmapped or misaligned writes leave every register unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH   = 5;
  localparam int LAST_CH  = NUM_CH - 1;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 32;
  localparam int CTRL_OFS = 'h08;
  localparam int CH_BASE  = 'h0C;
  localparam int CH_STEP  = 'hC;

  typedef enum logic [2:0] {K_NONE, K_CTRL, K_CBUF, K_CMP, K_OBS} acc_kind_e;

  typedef struct packed {
    acc_kind_e         kind;
    logic [CH_W-1:0]   ch;
  } acc_t;

  // control-word bit positions per channel
  function automatic int start_bit(input int i);
    return (i == 0) ? 0 : 4 * i + 4;
  endfunction

  function automatic int man_bit(input int i);
    return start_bit(i) + 1;
  endfunction

  function automatic int arl_bit(input int i);
    return (i == LAST_CH) ? 22 : start_bit(i) + 3;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      m[start_bit(i)] = 1'b1;
      m[man_bit(i)]   = 1'b1;
      m[arl_bit(i)]   = 1'b1;
      if (i != LAST_CH) m[start_bit(i) + 2] = 1'b1;
    end
    return m;
  endfunction

  function automatic int cbuf_ofs(input int i);
    return CH_BASE + CH_STEP * i;
  endfunction

  function automatic int obs_ofs(input int i);
    return (i == LAST_CH) ? cbuf_ofs(i) + 4 : cbuf_ofs(i) + 8;
  endfunction

  function automatic acc_t decode(input logic [ADDR_W-1:0] a);
    acc_t r;
    int   ai;
    r.kind = K_NONE;
    r.ch   = '0;
    ai     = int'(a);
    if (ai == CTRL_OFS) r.kind = K_CTRL;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ai == cbuf_ofs(i)) begin
        r.kind = K_CBUF;
        r.ch   = CH_W'(i);
      end
      if (i != LAST_CH && ai == cbuf_ofs(i) + 4) begin
        r.kind = K_CMP;
        r.ch   = CH_W'(i);
      end
      if (ai == obs_ofs(i)) begin
        r.kind = K_OBS;
        r.ch   = CH_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             start_rise_i,
  input  logic             start_fall_i,
  input  logic             arl_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stop_req_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_q;
  logic             hit;

  assign hit        = run_q && tick_i && (cnt_q == '0);
  assign stop_req_o = hit && !arl_i;
  assign cnt_o      = cnt_q;
  assign expire_o   = exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= hit;
      if (load_i)                cnt_q <= buf_i;
      else if (hit)              begin if (arl_i) cnt_q <= buf_i; end
      else if (run_q && tick_i)  cnt_q <= cnt_q - 1'b1;

      if (start_rise_i)          run_q <= 1'b1;
      else if (start_fall_i)     run_q <= 1'b0;
      else if (hit && !arl_i)    run_q <= 1'b0;
    end
  end

  // R4: manual update loads the buffer
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(buf_i));
  // R6: no tick, no load -> value held
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !tick_i) |=> cnt_q == $past(cnt_q));
  // R6: decrement by one
  a_r6_dec: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R7: strobe follows a zero-count tick
  a_r7_strobe: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && cnt_q == '0) |=> expire_o);
  // R8: reload on auto-reload expiry
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && cnt_q == '0 && arl_i && !load_i) |=> (cnt_q == $past(buf_i) && run_q));
  // R9: one-shot expiry halts
  a_r9_halt: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && cnt_q == '0 && !arl_i && !start_rise_i) |=> !run_q);
endmodule

// File: rtl/tmr_readmux.sv
module tmr_readmux
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                ctrl_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cbuf_i,
  input  logic [NUM_CH-2:0][DATA_W-1:0]    cmp_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     live_i,
  output logic [DATA_W-1:0]                data_o
);
  acc_t acc;

  always_comb begin
    acc    = decode(addr_i);
    data_o = '0;
    if (acc.kind == K_CTRL) data_o = ctrl_i;
    for (int i = 0; i < NUM_CH; i++) begin
      if (acc.ch == CH_W'(i)) begin
        if (acc.kind == K_CBUF) data_o = DATA_W'(cbuf_i[i]);
        if (acc.kind == K_OBS)  data_o = DATA_W'(live_i[i]);
      end
    end
    for (int i = 0; i < NUM_CH - 1; i++) begin
      if (acc.ch == CH_W'(i) && acc.kind == K_CMP) data_o = cmp_i[i];
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [4:0]        tick_i,
  output logic [4:0]        expire_o
);
  localparam logic [DATA_W-1:0] MASK = ctrl_mask();

  logic [DATA_W-1:0]             ctrl_q, ctrl_eff, clr;
  logic [NUM_CH-1:0][CNT_W-1:0]  cbuf_q, live;
  logic [NUM_CH-2:0][DATA_W-1:0] cmp_q;
  logic [NUM_CH-1:0]             load, s_rise, s_fall, arl, stop_req;
  logic [DATA_W-1:0]             rd_val;
  logic [DATA_W-1:0]             rdata_q;
  acc_t                          wacc;
  logic                          wr_ctrl;

  assign wacc    = decode(bus_addr);
  assign wr_ctrl = bus_wr && (wacc.kind == K_CTRL);

  always_comb begin
    clr = '0;
    for (int i = 0; i < NUM_CH; i++) clr[start_bit(i)] = stop_req[i];
    ctrl_eff = ctrl_q & ~clr;
    for (int i = 0; i < NUM_CH; i++) begin
      load[i]   = wr_ctrl && bus_wdata[man_bit(i)] && !ctrl_eff[man_bit(i)];
      s_rise[i] = wr_ctrl && bus_wdata[start_bit(i)] && !ctrl_eff[start_bit(i)];
      s_fall[i] = wr_ctrl && !bus_wdata[start_bit(i)] && ctrl_eff[start_bit(i)];
      arl[i]    = ctrl_q[arl_bit(i)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cbuf_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= wr_ctrl ? (bus_wdata & MASK) : ctrl_eff;
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_wr && wacc.kind == K_CBUF && wacc.ch == CH_W'(i))
          cbuf_q[i] <= bus_wdata[CNT_W-1:0];
      end
      for (int i = 0; i < NUM_CH - 1; i++) begin
        if (bus_wr && wacc.kind == K_CMP && wacc.ch == CH_W'(i))
          cmp_q[i] <= bus_wdata;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W)) u_ch (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i[g]),
        .load_i       (load[g]),
        .start_rise_i (s_rise[g]),
        .start_fall_i (s_fall[g]),
        .arl_i        (arl[g]),
        .buf_i        (cbuf_q[g]),
        .cnt_o        (live[g]),
        .stop_req_o   (stop_req[g]),
        .expire_o     (expire_o[g])
      );

      // R9: one-shot expiry clears the start bit
      a_r9_selfclear: assert property (@(posedge clk) disable iff (rst)
        (stop_req[g] && !wr_ctrl) |=> !ctrl_q[start_bit(g)]);
    end
  endgenerate

  tmr_readmux #(.CNT_W(CNT_W)) u_rd (
    .addr_i (bus_addr),
    .ctrl_i (ctrl_q),
    .cbuf_i (cbuf_q),
    .cmp_i  (cmp_q),
    .live_i (live),
    .data_o (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end
  assign bus_rdata = rdata_q;

  // R3: unused control bits never stored
  a_r3_mask: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (ctrl_q & ~MASK) == '0);
endmodule

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_i = '0;
  logic [4:0]  expire_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .expire_o(expire_o)
  );

  // addr, write data, expected read-back
  localparam logic [6:0][0:0] DUMMY = '0;
  localparam int NV = 14;
  localparam logic [NV-1:0][70:0] VEC = {
    {7'h0C, 32'h1234_5678, 32'h1234_5678},
    {7'h0E, 32'hDEAD_BEEF, 32'h0000_0000},
    {7'h10, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {7'h18, 32'h0000_0011, 32'h0000_0011},
    {7'h1C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {7'h24, 32'h0000_0022, 32'h0000_0022},
    {7'h28, 32'h0000_0033, 32'h0000_0033},
    {7'h30, 32'h0000_0044, 32'h0000_0044},
    {7'h34, 32'h0000_0055, 32'h0000_0055},
    {7'h3C, 32'h0000_0066, 32'h0000_0066},
    {7'h44, 32'hFFFF_FFFF, 32'h0000_0000},
    {7'h00, 32'h0000_1234, 32'h0000_0000},
    {7'h08, 32'hFF80_00F0, 32'h0000_0000},
    {7'h14, 32'h0000_0005, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tick(input int ch, output logic ex);
    @(negedge clk);
    tick_i = 5'(1 << ch);
    @(negedge clk);
    ex = expire_o[ch];
    tick_i = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic ex;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(7'h08, v); chk("R1 ctrl", v, 0);
    rd(7'h0C, v); chk("R1 cbuf0", v, 0);
    rd(7'h10, v); chk("R1 cmp0", v, 0);
    rd(7'h14, v); chk("R1 obs0", v, 0);
    rd(7'h40, v); chk("R1 obs4", v, 0);
    chk("R1 expire", 32'(expire_o), 0);

    // table walk: R2 map, R3 mask, R10 obs read-only, R11 unmapped
    for (int k = NV - 1; k >= 0; k--) begin
      wr(VEC[k][70:64], VEC[k][63:32]);
      rd(VEC[k][70:64], v);
      chk("R2/R3/R10/R11 table", v, VEC[k][31:0]);
    end
    rd(7'h0C, v); chk("R11 misaligned write ignored", v, 32'h1234_5678);

    // ch0 one-shot
    wr(7'h0C, 3);
    wr(7'h08, 32'h2);
    rd(7'h14, v); chk("R4 manual load", v, 3);
    wr(7'h08, 32'h1);
    tick(0, ex); chk("R6 dec", 32'(ex), 0);
    rd(7'h14, v); chk("R6 dec value", v, 2);
    repeat (4) @(negedge clk);
    rd(7'h14, v); chk("R6 hold without tick", v, 2);
    tick(0, ex); tick(0, ex);
    rd(7'h14, v); chk("R6 reach zero", v, 0);
    chk("R7 no strobe before expiry", 32'(ex), 0);
    tick(0, ex); chk("R7 strobe", 32'(ex), 1);
    @(negedge clk); chk("R7 strobe one cycle", 32'(expire_o[0]), 0);
    rd(7'h08, v); chk("R9 start cleared", v, 0);
    tick(0, ex); chk("R9 no strobe after halt", 32'(ex), 0);
    rd(7'h14, v); chk("R9 count held", v, 0);

    // held manual-update bit
    wr(7'h0C, 7);
    wr(7'h08, 32'h2);
    wr(7'h0C, 9);
    wr(7'h08, 32'h2);
    rd(7'h14, v); chk("R4 no reload on held bit", v, 7);

    // ch1 auto-reload
    wr(7'h18, 2);
    wr(7'h08, 32'h200);
    wr(7'h08, 32'h900);
    tick(1, ex); tick(1, ex);
    rd(7'h20, v); chk("R6 ch1 zero", v, 0);
    tick(1, ex); chk("R7 ch1 strobe", 32'(ex), 1);
    rd(7'h20, v); chk("R8 reload value", v, 2);
    rd(7'h08, v); chk("R8 start kept", v, 32'h900);
    tick(1, ex);
    rd(7'h20, v); chk("R8 keeps running", v, 1);
    wr(7'h08, 32'h0);
    tick(1, ex);
    rd(7'h20, v); chk("R5 stopped holds", v, 1);
    wr(7'h08, 32'h100);
    tick(1, ex);
    rd(7'h20, v); chk("R5 resume", v, 0);
    wr(7'h08, 32'h0);

    // ch4 auto-reload at bit 22
    wr(7'h3C, 1);
    wr(7'h08, 32'h0020_0000);
    rd(7'h40, v); chk("R10 obs4 after load", v, 1);
    wr(7'h08, 32'h0050_0000);
    tick(4, ex);
    rd(7'h40, v); chk("R6 ch4 dec", v, 0);
    tick(4, ex); chk("R7 ch4 strobe", 32'(ex), 1);
    rd(7'h40, v); chk("R8 ch4 reload", v, 1);
    rd(7'h08, v); chk("R3 ch4 bits", v, 32'h0050_0000);
    rd(7'h3C, v); chk("R2 ch4 cbuf", v, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule